// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This unit works beside a small integer ALU. It takes two operands, an operation code and an operand-size select. From these it produces the operation result and six arithmetic status flags: carry, parity, auxiliary carry, zero, sign and overflow. The operation can be an add, a subtract or a bitwise logic operation, on 8-, 16- or 32-bit data.

The result comes out combinationally from the current inputs. The six flags are captured into a register on the rising clock edge, but only while the flag-write enable is high. This lets the surrounding datapath compute a value without disturbing the flags it holds.

Each flag is taken at the selected operand size. Operand bits above that size are ignored, and result bits above it read as zero. A flag that depends on the most significant bit uses the top bit of the selected size.

Top module: `aflag_unit`

## Requirements
- R1: With op code 3'b000 (add), carry (flags bit 0) is the carry out of the top bit of the selected size.
- R2: With op code 3'b001 (subtract, first operand minus second), carry (flags bit 0) is 1 exactly when the masked first operand is unsigned-less than the masked second operand, which is the borrow.
- R3: Parity (flags bit 1) is 1 when result bits 7..0 hold an even number of ones and 0 when they hold an odd number, at every size.
- R4: Auxiliary carry (flags bit 2) is the carry out of bit 3 into bit 4 for an add, and the borrow from bit 4 into bit 3 for a subtract.
- R5: Zero (flags bit 3) is 1 exactly when the size-masked result is zero.
- R6: Sign (flags bit 4) equals the top bit of the result at the selected size (bit 7, 15 or 31).
- R7: Overflow (flags bit 5) is set for an add when both operands share a sign and the result sign differs from it. It is set for a subtract when the operand signs differ and the result sign differs from the first operand.
- R8: Op codes 3'b010, 3'b011 and 3'b100 give AND, OR and XOR. For these, carry, auxiliary carry and overflow are 0. Any other op code gives a zero result with those three flags at 0.
- R9: Size select 2'b00 is 8-bit, 2'b01 is 16-bit, and 2'b10 or 2'b11 is 32-bit. Operand bits above the size are ignored, and result bits above it are 0.
- R10: While the flag-write enable is low, the flags register keeps its value across clock edges.
- R11: A high synchronous reset clears all flags to 0 at the next rising edge, whatever the enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_code | input | 3 | Operation select (add, subtract, AND, OR, XOR) |
| size_sel | input | 2 | Operand size select |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| flag_we | input | 1 | Flag-write enable |
| result | output | 32 | Size-masked operation result, combinational |
| flags_q | output | 6 | Flags register: bit 5 overflow, 4 sign, 3 zero, 2 auxiliary carry, 1 parity, 0 carry |

## Verification
The assertions compare each registered flag with the value that `result` had in the cycle before it was captured. This only works if `op_code`, `size_sel` and the operands stay steady from one falling edge through the next rising edge. The stimulus therefore changes every input only on the falling edge.

The assertions also assume that reset is driven to a known level from the start, and that the enable is never X. The bench sets both at time zero and keeps them as plain 0/1 values. The vectors cover all four size codes, every defined op code, and operands with bits set above the selected size.

// File: rtl/aflag_pkg.sv
package aflag_pkg;
  localparam int DATA_W = 32;
  localparam int IDX_W  = $clog2(DATA_W + 1);
  localparam int NIB_W  = 4;

  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_AND = 3'b010,
    OP_OR  = 3'b011,
    OP_XOR = 3'b100
  } op_e;

  typedef enum logic [1:0] {
    SZ_8  = 2'b00,
    SZ_16 = 2'b01,
    SZ_32 = 2'b10,
    SZ_32B = 2'b11
  } size_e;

  typedef struct packed {
    logic ovf;
    logic sign;
    logic zero;
    logic aux;
    logic parity;
    logic carry;
  } flags_t;

  // operand width in bits for a size code
  function automatic logic [IDX_W-1:0] width_of(input logic [1:0] sz);
    case (sz)
      SZ_8:    width_of = IDX_W'(8);
      SZ_16:   width_of = IDX_W'(16);
      default: width_of = IDX_W'(DATA_W);
    endcase
  endfunction

  // mask that keeps only the bits of the selected size
  function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (IDX_W'(i) < width_of(sz));
    return m;
  endfunction

  // top bit of a value at the selected size
  function automatic logic top_bit(input logic [DATA_W-1:0] v, input logic [1:0] sz);
    return v[width_of(sz) - IDX_W'(1)];
  endfunction
endpackage

// File: rtl/aflag_alu.sv
module aflag_alu
  import aflag_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [2:0]   op_code,
  input  logic [1:0]   size_sel,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] result,
  output logic         carry_ev,
  output logic         aux_ev,
  output logic         ovf_ev
);
  logic [W-1:0]   mask, a_m, b_m;
  logic [W:0]     sum_x, dif_x;
  logic [IDX_W-1:0] wd;
  logic [NIB_W:0] nib_sum, nib_dif;
  logic           a_s, b_s, r_s;

  always_comb begin
    wd    = width_of(size_sel);
    mask  = size_mask(size_sel);
    a_m   = opnd_a & mask;
    b_m   = opnd_b & mask;
    sum_x = {1'b0, a_m} + {1'b0, b_m};
    dif_x = {1'b0, a_m} - {1'b0, b_m};
    nib_sum = {1'b0, a_m[NIB_W-1:0]} + {1'b0, b_m[NIB_W-1:0]};
    nib_dif = {1'b0, a_m[NIB_W-1:0]} - {1'b0, b_m[NIB_W-1:0]};
    a_s = top_bit(a_m, size_sel);
    b_s = top_bit(b_m, size_sel);
    result   = '0;
    carry_ev = 1'b0;
    aux_ev   = 1'b0;
    ovf_ev   = 1'b0;
    case (op_code)
      OP_ADD: begin
        result   = sum_x[W-1:0] & mask;
        carry_ev = sum_x[wd];
        aux_ev   = nib_sum[NIB_W];
      end
      OP_SUB: begin
        result   = dif_x[W-1:0] & mask;
        carry_ev = dif_x[wd];
        aux_ev   = nib_dif[NIB_W];
      end
      OP_AND: result = a_m & b_m;
      OP_OR:  result = a_m | b_m;
      OP_XOR: result = a_m ^ b_m;
      default: result = '0;
    endcase
    r_s = top_bit(result, size_sel);
    if (op_code == OP_ADD) ovf_ev = (a_s == b_s) && (r_s != a_s);
    else if (op_code == OP_SUB) ovf_ev = (a_s != b_s) && (r_s != a_s);
  end
endmodule

// File: rtl/aflag_eval.sv
module aflag_eval
  import aflag_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] result,
  input  logic [1:0]   size_sel,
  output logic         parity_ev,
  output logic         zero_ev,
  output logic         sign_ev
);
  always_comb begin
    parity_ev = ~(^result[7:0]);
    zero_ev   = (result == '0);
    sign_ev   = top_bit(result, size_sel);
  end
endmodule

// File: rtl/aflag_unit.sv
module aflag_unit
  import aflag_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   op_code,
  input  logic [1:0]   size_sel,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         flag_we,
  output logic [W-1:0] result,
  output logic [5:0]   flags_q
);
  logic   carry_ev, aux_ev, ovf_ev, parity_ev, zero_ev, sign_ev;
  flags_t flags_d, flags_r;
  logic   logic_op;
  logic   res_msb;

  aflag_alu #(.W(W)) u_alu (
    .op_code(op_code), .size_sel(size_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .result(result), .carry_ev(carry_ev), .aux_ev(aux_ev), .ovf_ev(ovf_ev)
  );

  aflag_eval #(.W(W)) u_eval (
    .result(result), .size_sel(size_sel),
    .parity_ev(parity_ev), .zero_ev(zero_ev), .sign_ev(sign_ev)
  );

  always_comb begin
    flags_d = '{ovf: ovf_ev, sign: sign_ev, zero: zero_ev,
                aux: aux_ev, parity: parity_ev, carry: carry_ev};
  end

  always_ff @(posedge clk) begin
    if (rst)          flags_r <= '0;
    else if (flag_we) flags_r <= flags_d;
  end

  assign flags_q = flags_r;

  // observation wires for the checks below
  assign logic_op = (op_code == OP_AND) || (op_code == OP_OR) || (op_code == OP_XOR);
  assign res_msb  = (size_sel == SZ_8)  ? result[7] :
                    (size_sel == SZ_16) ? result[15] : result[W-1];

  p_parity_r3: assert property (@(posedge clk) disable iff (rst)
    flag_we |=> flags_q[1] == ($countones($past(result[7:0])) % 2 == 0));
  p_zero_r5: assert property (@(posedge clk) disable iff (rst)
    flag_we |=> flags_q[3] == ($past(result) == '0));
  p_sign_r6: assert property (@(posedge clk) disable iff (rst)
    flag_we |=> flags_q[4] == $past(res_msb));
  p_logic_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (flag_we && logic_op) |=> (flags_q[0] == 1'b0 && flags_q[2] == 1'b0 && flags_q[5] == 1'b0));
  p_upper_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (size_sel == SZ_8) |-> (result[W-1:8] == '0));
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !flag_we |=> $stable(flags_q));
endmodule

// File: tb/test_aflag_unit.sv
`timescale 1ns/1ps
module test_aflag_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_code = 3'd0;
  logic [1:0]  size_sel = 2'd0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic        flag_we = 1'b0;
  logic [31:0] result;
  logic [5:0]  flags_q;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct {
    logic [31:0] res;
    logic [5:0]  flg;
    string       tag;
  } item_t;
  item_t sb_q[$];
  logic [5:0] model_flags = 6'd0;

  aflag_unit i_aflag_unit (
    .clk(clk), .rst(rst), .op_code(op_code), .size_sel(size_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .flag_we(flag_we),
    .result(result), .flags_q(flags_q)
  );

  always #2 clk = ~clk;

  // reference model written from the requirements; {flags, result}
  function automatic logic [37:0] ref_model(input logic [2:0] op, input logic [1:0] sz,
                                           input logic [31:0] a, input logic [31:0] b);
    longint unsigned w, m, am, bm, r, half;
    longint sa, sb, sr;
    logic c, p, ax, z, s, o;
    w = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
    m = (64'd1 << w) - 1;
    half = 64'd1 << (w - 1);
    am = a & m; bm = b & m;
    sa = (am >= half) ? longint'(am) - longint'(2 * half) : longint'(am);
    sb = (bm >= half) ? longint'(bm) - longint'(2 * half) : longint'(bm);
    c = 0; ax = 0; o = 0; r = 0;
    case (op)
      3'b000: begin
        r = (am + bm) & m; c = (am + bm) > m;
        ax = ((am % 16) + (bm % 16)) >= 16;
        sr = sa + sb; o = (sr >= longint'(half)) || (sr < -longint'(half));
      end
      3'b001: begin
        r = (am - bm) & m; c = am < bm;
        ax = (am % 16) < (bm % 16);
        sr = sa - sb; o = (sr >= longint'(half)) || (sr < -longint'(half));
      end
      3'b010: r = am & bm;
      3'b011: r = am | bm;
      3'b100: r = am ^ bm;
      default: r = 0;
    endcase
    p = ($countones(r & 64'hFF) % 2) == 0;
    z = (r == 0);
    s = (r >= half);
    return {o, s, z, ax, p, c, r[31:0]};
  endfunction

  task automatic drive(input logic [2:0] op, input logic [1:0] sz, input logic [31:0] a,
                       input logic [31:0] b, input logic we, input logic rs, input string tag);
    logic [37:0] e;
    item_t it;
    @(negedge clk);
    op_code = op; size_sel = sz; opnd_a = a; opnd_b = b; flag_we = we; rst = rs;
    e = ref_model(op, sz, a, b);
    if (rs) model_flags = 6'd0;
    else if (we) model_flags = e[37:32];
    it.res = e[31:0]; it.flg = model_flags; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (result !== it.res) begin
          errors++;
          $display("FAIL %s result actual=%h expected=%h", it.tag, result, it.res);
        end
        checks++;
        if (flags_q !== it.flg) begin
          errors++;
          $display("FAIL %s flags actual=%b expected=%b", it.tag, flags_q, it.flg);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    // R11 reset state
    drive(3'b000, 2'b00, 32'h1, 32'h1, 1'b1, 1'b1, "R11_reset");
    drive(3'b000, 2'b00, 32'h1, 32'h1, 1'b0, 1'b1, "R11_reset");
    // R1 R4 R5 carry out of top bit, nibble carry, zero
    drive(3'b000, 2'b00, 32'hFF, 32'h01, 1'b1, 1'b0, "R1_R4_R5");
    // R7 R6 signed add overflow
    drive(3'b000, 2'b00, 32'h7F, 32'h01, 1'b1, 1'b0, "R7_R6");
    // R2 borrow
    drive(3'b001, 2'b00, 32'h00, 32'h01, 1'b1, 1'b0, "R2");
    // R7 subtract overflow at 16 bits
    drive(3'b001, 2'b01, 32'h8000, 32'h0001, 1'b1, 1'b0, "R7_sub16");
    // R1 32-bit carry
    drive(3'b000, 2'b10, 32'hFFFFFFFF, 32'h1, 1'b1, 1'b0, "R1_32");
    // R9 upper operand bits ignored
    drive(3'b000, 2'b01, 32'hABCD1234, 32'h11110001, 1'b1, 1'b0, "R9_mask");
    drive(3'b001, 2'b11, 32'h00000010, 32'h00000001, 1'b1, 1'b0, "R9_size11_R4");
    // R3 parity odd then even
    drive(3'b011, 2'b00, 32'h01, 32'h00, 1'b1, 1'b0, "R3_odd");
    drive(3'b011, 2'b10, 32'h03000000, 32'h03, 1'b1, 1'b0, "R3_even");
    // R8 logic clears C A O after a carry-setting add
    drive(3'b000, 2'b00, 32'h8F, 32'h81, 1'b1, 1'b0, "R8_pre");
    drive(3'b010, 2'b00, 32'hF0, 32'hFF, 1'b1, 1'b0, "R8_and");
    drive(3'b000, 2'b00, 32'h8F, 32'h81, 1'b1, 1'b0, "R8_pre");
    drive(3'b100, 2'b01, 32'hFFFF, 32'hFFFF, 1'b1, 1'b0, "R8_xor");
    drive(3'b111, 2'b10, 32'h1234, 32'h5678, 1'b1, 1'b0, "R8_undef");
    // R10 hold while enable low
    drive(3'b000, 2'b00, 32'hFF, 32'h01, 1'b1, 1'b0, "R10_set");
    drive(3'b011, 2'b00, 32'h01, 32'h00, 1'b0, 1'b0, "R10_hold");
    drive(3'b001, 2'b10, 32'h0, 32'h5, 1'b0, 1'b0, "R10_hold");
    // R11 reset wins over enable
    drive(3'b000, 2'b00, 32'hFF, 32'h01, 1'b1, 1'b1, "R11_mid");
    // mixed vectors
    for (int i = 0; i < 400; i++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 5));
      drive(op, 2'($urandom_range(0, 3)), $urandom, $urandom,
            1'($urandom_range(0, 3) != 0), 1'b0, "R6_R7_mix");
    end
    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule